// File: doc/BRIEF.md
# Performance counter control unit

This block holds the control word of a performance-monitoring facility and the counters that the word governs. The counters are one free-running cycle counter and a small bank of event counters. A single write strobe loads the control word. Two of its bits are one-shot commands that clear counters. The other bits select the counting behaviour: master enable, divide-by-64 cycle counting, export enable, stopping the cycle counter while debug is prohibited, and the bit position at which the cycle counter reports an overflow.

The surrounding core supplies three kinds of input. The first is the current privilege level and security state. The second is a hypervisor split count: event counters whose index is at or above this count belong to the hypervisor. The third is a debug-prohibit flag. In non-secure user or kernel context, the master enable and the event-clear command do not reach the counters owned by the hypervisor. Those counters also hold their value in that context. Each counter keeps a sticky overflow flag. Only the block reset clears these flags.

All pins are plain control and status pins. There is no streaming data path, so no valid/ready handshake and no back-pressure. A write is taken on every clock edge where `wr_en` is high.

Top module: `perf_ctl_unit`

## Requirements
- R1: After reset, `ctrl_rd` is 0, every counter is 0, every overflow flag is 0 and `export_en` is 0.
- R2: While the enable bit (bit 0) is 0, neither the cycle counter nor any event counter changes, except through a clear command.
- R3: A control write takes effect from the clock edge that follows its write edge. With the enable bit at 1 and the divide bit (bit 3) at 0, the cycle counter advances by one on every clock.
- R4: With the long-overflow bit (bit 6) at 0, `cyc_ovf` is set by an increment that takes bit SHORT_W-1 from 1 to 0. With bit 6 at 1, `cyc_ovf` is set only by an increment that takes the top bit from 1 to 0.
- R5: `ctrl_rd` returns the stored control word at the write positions: enable 0, event clear 1, cycle clear 2, divide 3, export 4, prohibit-stop 5, long-overflow 6. Bits 1 and 2 always read 0.
- R6: Writing 1 to bit 1 clears the event counters on the write edge. It leaves the cycle counter counting as usual.
- R7: Writing 1 to bit 2 clears the cycle counter on the write edge. This clear takes priority over an increment in the same cycle, and no overflow is recorded for that cycle. Neither clear command changes any overflow flag.
- R8: With bit 3 at 1, the cycle counter advances once per 64 running clocks. The prescaler is cleared by a cycle-clear command, so the first advance comes 64 clocks after that write edge.
- R9: With bit 5 at 1 and `dbg_prohibit` high, the cycle counter holds while the event counters keep counting. With bit 5 at 0, `dbg_prohibit` has no effect.
- R10: An enabled event counter advances on each clock where its `evt_in` bit is high. Each counter sets its own `evt_ovf` bit when it wraps from all ones to zero.
- R11: When `ns_state` is 1 and `priv_lvl` is 0 or 1, event counters with index at or above `hyp_split` neither count nor clear. At `priv_lvl` 2 or 3, the event-clear command clears every event counter.
- R12: `export_en` follows bit 4 of the control word and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 7 | Control word to write |
| ctrl_rd | output | 7 | Control-word readback |
| priv_lvl | input | 2 | Privilege level 0 (user) to 3 (monitor) |
| ns_state | input | 1 | 1 when the core runs non-secure |
| hyp_split | input | $clog2(N_EVT+1) | Index of the first hypervisor-owned event counter |
| dbg_prohibit | input | 1 | Non-invasive debug not permitted or not enabled |
| evt_in | input | N_EVT | One event pulse per event counter |
| cyc_cnt | output | CYC_W | Cycle counter value |
| cyc_ovf | output | 1 | Sticky cycle-counter overflow flag |
| evt_cnt | output | N_EVT*EVT_W | Event counter values, counter 0 in the low bits |
| evt_ovf | output | N_EVT | Sticky per-counter overflow flags |
| export_en | output | 1 | Event export permission |

## Verification
The properties assume that `hyp_split` never exceeds N_EVT. They also assume that the privilege, security and debug inputs are settled at the clock edge that samples them, because the hold check for hypervisor-owned counters compares those inputs with the counter values one edge later. The stimulus changes every input only at the falling clock edge. It keeps `hyp_split` between 2 and N_EVT, and it moves between privilege levels only while the counters it inspects are not being cleared in a way that the level change would alter.

// File: rtl/perf_ctl_pkg.sv
package perf_ctl_pkg;
  localparam int CTL_W = 7;

  // Field order fixes the bit positions seen by software (MSB first).
  typedef struct packed {
    logic long_ovf;
    logic pd_stop;
    logic exp_en;
    logic div64;
    logic cyc_clr;
    logic evt_clr;
    logic enable;
  } ctl_t;

  typedef enum logic [1:0] {
    PRIV_USER   = 2'd0,
    PRIV_KERNEL = 2'd1,
    PRIV_HYP    = 2'd2,
    PRIV_MON    = 2'd3
  } priv_e;
endpackage

// File: rtl/perf_ctl_reg.sv
module perf_ctl_reg
  import perf_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output ctl_t             ctl_q,
  output logic             evt_clr,
  output logic             cyc_clr
);
  ctl_t wr_word;
  ctl_t keep_word;

  assign wr_word = ctl_t'(wr_data);

  // Command bits are one-shot: they act on the write edge and are never stored.
  always_comb begin
    keep_word         = wr_word;
    keep_word.evt_clr = 1'b0;
    keep_word.cyc_clr = 1'b0;
  end

  assign evt_clr = wr_en && wr_word.evt_clr;
  assign cyc_clr = wr_en && wr_word.cyc_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= keep_word;
  end
endmodule

// File: rtl/perf_cyc_ctr.sv
module perf_cyc_ctr #(
  parameter int CYC_W    = 64,
  parameter int SHORT_W  = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_sel,
  input  logic             long_sel,
  input  logic             clr,
  output logic [CYC_W-1:0] cnt,
  output logic             ovf
);
  logic [DIV_LOG2-1:0] pre_q;
  logic [CYC_W-1:0]    cnt_q;
  logic [CYC_W-1:0]    cnt_nx;
  logic                tick;
  logic                wrap;

  assign tick   = run && (!div_sel || (&pre_q));
  assign cnt_nx = cnt_q + CYC_W'(1);
  assign wrap   = long_sel ? (cnt_q[CYC_W-1]   && !cnt_nx[CYC_W-1])
                           : (cnt_q[SHORT_W-1] && !cnt_nx[SHORT_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (run && div_sel) pre_q <= pre_q + DIV_LOG2'(1);
      if (tick)           cnt_q <= cnt_nx;
      if (tick && wrap)   ovf   <= 1'b1;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/perf_part_mask.sv
module perf_part_mask
  import perf_ctl_pkg::*;
#(
  parameter int N_EVT   = 4,
  parameter int SPLIT_W = $clog2(N_EVT + 1)
) (
  input  logic [1:0]         priv_lvl,
  input  logic               ns_state,
  input  logic [SPLIT_W-1:0] hyp_split,
  output logic [N_EVT-1:0]   reach
);
  logic low_ns;

  assign low_ns = ns_state && ((priv_lvl == PRIV_USER) || (priv_lvl == PRIV_KERNEL));

  for (genvar i = 0; i < N_EVT; i++) begin : g_reach
    assign reach[i] = !(low_ns && (i >= int'(hyp_split)));
  end
endmodule

// File: rtl/perf_evt_bank.sv
module perf_evt_bank #(
  parameter int N_EVT = 4,
  parameter int EVT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EVT-1:0]   evt_in,
  input  logic [N_EVT-1:0]   cnt_en,
  input  logic [N_EVT-1:0]   clr_mask,
  output logic [N_EVT*EVT_W-1:0] cnt,
  output logic [N_EVT-1:0]   ovf
);
  for (genvar i = 0; i < N_EVT; i++) begin : g_ctr
    logic [EVT_W-1:0] val_q;
    logic             bump;

    assign bump = cnt_en[i] && evt_in[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q  <= '0;
        ovf[i] <= 1'b0;
      end else if (clr_mask[i]) begin
        val_q <= '0;
      end else if (bump) begin
        val_q <= val_q + EVT_W'(1);
        if (&val_q) ovf[i] <= 1'b1;
      end
    end

    assign cnt[i*EVT_W +: EVT_W] = val_q;
  end
endmodule

// File: rtl/perf_ctl_unit.sv
module perf_ctl_unit
  import perf_ctl_pkg::*;
#(
  parameter int N_EVT    = 4,
  parameter int EVT_W    = 32,
  parameter int CYC_W    = 64,
  parameter int SHORT_W  = 32,
  parameter int DIV_LOG2 = 6,
  localparam int SPLIT_W = $clog2(N_EVT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CTL_W-1:0]       wr_data,
  output logic [CTL_W-1:0]       ctrl_rd,
  input  logic [1:0]             priv_lvl,
  input  logic                   ns_state,
  input  logic [SPLIT_W-1:0]     hyp_split,
  input  logic                   dbg_prohibit,
  input  logic [N_EVT-1:0]       evt_in,
  output logic [CYC_W-1:0]       cyc_cnt,
  output logic                   cyc_ovf,
  output logic [N_EVT*EVT_W-1:0] evt_cnt,
  output logic [N_EVT-1:0]       evt_ovf,
  output logic                   export_en
);
  ctl_t             ctl;
  logic             evt_clr;
  logic             cyc_clr;
  logic             cyc_run;
  logic [N_EVT-1:0] reach;

  perf_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctl_q   (ctl),
    .evt_clr (evt_clr),
    .cyc_clr (cyc_clr)
  );

  assign cyc_run = ctl.enable && !(ctl.pd_stop && dbg_prohibit);

  perf_cyc_ctr #(
    .CYC_W    (CYC_W),
    .SHORT_W  (SHORT_W),
    .DIV_LOG2 (DIV_LOG2)
  ) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cyc_run),
    .div_sel  (ctl.div64),
    .long_sel (ctl.long_ovf),
    .clr      (cyc_clr),
    .cnt      (cyc_cnt),
    .ovf      (cyc_ovf)
  );

  perf_part_mask #(
    .N_EVT   (N_EVT),
    .SPLIT_W (SPLIT_W)
  ) u_mask (
    .priv_lvl  (priv_lvl),
    .ns_state  (ns_state),
    .hyp_split (hyp_split),
    .reach     (reach)
  );

  perf_evt_bank #(
    .N_EVT (N_EVT),
    .EVT_W (EVT_W)
  ) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_in   (evt_in),
    .cnt_en   (reach & {N_EVT{ctl.enable}}),
    .clr_mask (reach & {N_EVT{evt_clr}}),
    .cnt      (evt_cnt),
    .ovf      (evt_ovf)
  );

  assign ctrl_rd   = CTL_W'(ctl);
  assign export_en = ctl.exp_en;
endmodule

// File: rtl/perf_ctl_chk.sv
module perf_ctl_chk #(
  parameter int N_EVT = 4,
  parameter int EVT_W = 32,
  parameter int CYC_W = 64,
  localparam int SPLIT_W = $clog2(N_EVT + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_cyc,
  input logic                   wr_evt,
  input logic                   en_bit,
  input logic                   pd_bit,
  input logic [1:0]             priv_lvl,
  input logic                   ns_state,
  input logic [SPLIT_W-1:0]     hyp_split,
  input logic                   dbg_prohibit,
  input logic [CYC_W-1:0]       cyc_cnt,
  input logic                   cyc_ovf,
  input logic [N_EVT*EVT_W-1:0] evt_cnt,
  input logic [N_EVT-1:0]       evt_ovf
);
  a_r2_all_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_bit && !wr_cyc && !wr_evt) |=> ($stable(cyc_cnt) && $stable(evt_cnt)));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cyc |=> (cyc_cnt == $past(cyc_cnt) || cyc_cnt == $past(cyc_cnt) + CYC_W'(1)));

  a_r7_cyc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc |=> (cyc_cnt == '0 && cyc_ovf == $past(cyc_ovf)));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ovf |=> cyc_ovf);

  a_r10_evt_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_ovf) |=> ((evt_ovf & $past(evt_ovf)) == $past(evt_ovf)));

  a_r9_prohibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_bit && pd_bit && dbg_prohibit && !wr_cyc) |=> $stable(cyc_cnt));

  for (genvar i = 0; i < N_EVT; i++) begin : g_res
    a_r11_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ns_state && priv_lvl < 2'd2 && i >= int'(hyp_split))
        |=> $stable(evt_cnt[i*EVT_W +: EVT_W]));
  end
endmodule

bind perf_ctl_unit perf_ctl_chk #(
  .N_EVT (N_EVT),
  .EVT_W (EVT_W),
  .CYC_W (CYC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_cyc       (wr_en && wr_data[2]),
  .wr_evt       (wr_en && wr_data[1]),
  .en_bit       (ctrl_rd[0]),
  .pd_bit       (ctrl_rd[5]),
  .priv_lvl     (priv_lvl),
  .ns_state     (ns_state),
  .hyp_split    (hyp_split),
  .dbg_prohibit (dbg_prohibit),
  .cyc_cnt      (cyc_cnt),
  .cyc_ovf      (cyc_ovf),
  .evt_cnt      (evt_cnt),
  .evt_ovf      (evt_ovf)
);

// File: tb/perf_ctl_unit_bench.sv
module perf_ctl_unit_bench;
  localparam int N_EVT   = 4;
  localparam int EVT_W   = 4;
  localparam int CYC_W   = 12;
  localparam int SHORT_W = 6;
  localparam int SPLIT_W = $clog2(N_EVT + 1);

  localparam int SEL_CYC  = 0;
  localparam int SEL_COVF = 1;
  localparam int SEL_EVT  = 2;
  localparam int SEL_EOVF = 3;
  localparam int SEL_CTL  = 4;
  localparam int SEL_EXP  = 5;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   wr_en = 1'b0;
  logic [6:0]             wr_data = '0;
  logic [6:0]             ctrl_rd;
  logic [1:0]             priv_lvl = 2'd2;
  logic                   ns_state = 1'b1;
  logic [SPLIT_W-1:0]     hyp_split = SPLIT_W'(N_EVT);
  logic                   dbg_prohibit = 1'b0;
  logic [N_EVT-1:0]       evt_in = '0;
  logic [CYC_W-1:0]       cyc_cnt;
  logic                   cyc_ovf;
  logic [N_EVT*EVT_W-1:0] evt_cnt;
  logic [N_EVT-1:0]       evt_ovf;
  logic                   export_en;

  always #4 clk = ~clk;

  perf_ctl_unit #(
    .N_EVT   (N_EVT),
    .EVT_W   (EVT_W),
    .CYC_W   (CYC_W),
    .SHORT_W (SHORT_W)
  ) u_perf_ctl_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .ctrl_rd      (ctrl_rd),
    .priv_lvl     (priv_lvl),
    .ns_state     (ns_state),
    .hyp_split    (hyp_split),
    .dbg_prohibit (dbg_prohibit),
    .evt_in       (evt_in),
    .cyc_cnt      (cyc_cnt),
    .cyc_ovf      (cyc_ovf),
    .evt_cnt      (evt_cnt),
    .evt_ovf      (evt_ovf),
    .export_en    (export_en)
  );

  typedef struct {
    string            req;
    int               sel;
    int               idx;
    longint unsigned  exp;
  } item_t;

  item_t sb_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  event  chk_ev;

  function automatic longint unsigned pick(int sel, int idx);
    case (sel)
      SEL_CYC:  return 64'(cyc_cnt);
      SEL_COVF: return 64'(cyc_ovf);
      SEL_EVT:  return 64'(evt_cnt[idx*EVT_W +: EVT_W]);
      SEL_EOVF: return 64'(evt_ovf);
      SEL_CTL:  return 64'(ctrl_rd);
      default:  return 64'(export_en);
    endcase
  endfunction

  // Monitor: drains the scoreboard whenever the driver signals a settled point.
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        longint unsigned act;
        it  = sb_q.pop_front();
        act = pick(it.sel, it.idx);
        n_chk++;
        if (act != it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d idx=%0d actual=%0h expected=%0h",
                   it.req, it.sel, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic push(string req, int sel, int idx, longint unsigned exp);
    item_t it;
    it.req = req; it.sel = sel; it.idx = idx; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic settle();
    -> chk_ev;
    #1;
  endtask

  task automatic wr(logic [6:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      report();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;

    // R1: reset state
    push("R1 ctrl", SEL_CTL, 0, 0);
    push("R1 cyc", SEL_CYC, 0, 0);
    push("R1 covf", SEL_COVF, 0, 0);
    push("R1 eovf", SEL_EOVF, 0, 0);
    push("R1 export", SEL_EXP, 0, 0);
    settle();

    // R2: disabled, events present, nothing moves
    evt_in = 4'b0101;
    idle(10);
    push("R2 cyc held", SEL_CYC, 0, 0);
    push("R2 evt0 held", SEL_EVT, 0, 0);
    settle();

    // R3, R10: enabled counting, only asserted event inputs count
    wr(7'h01);
    idle(10);
    push("R3 cyc per clock", SEL_CYC, 0, 10);
    push("R10 evt0 counts", SEL_EVT, 0, 10);
    push("R10 evt1 idle", SEL_EVT, 1, 0);
    settle();

    // R6, R5: event clear spares the cycle counter; command bits read 0
    wr(7'h03);
    push("R6 cyc kept", SEL_CYC, 0, 11);
    push("R6 evt0 cleared", SEL_EVT, 0, 0);
    push("R5 raz", SEL_CTL, 0, 7'h01);
    settle();

    // R7: cycle clear, and priority over an overflowing increment
    wr(7'h05);
    push("R7 cyc cleared", SEL_CYC, 0, 0);
    push("R7 evt0 kept", SEL_EVT, 0, 1);
    settle();
    idle(63);
    push("R4 pre wrap", SEL_CYC, 0, 63);
    settle();
    wr(7'h05);
    push("R7 clear wins", SEL_CYC, 0, 0);
    push("R7 no ovf on clear", SEL_COVF, 0, 0);
    settle();

    // R4 short overflow, R10 event wrap flags
    idle(63);
    push("R4 before short wrap", SEL_COVF, 0, 0);
    settle();
    idle(1);
    push("R4 short ovf", SEL_COVF, 0, 1);
    push("R4 cyc", SEL_CYC, 0, 64);
    push("R10 evt ovf", SEL_EOVF, 0, 4'b0101);
    settle();

    // R7: clears leave overflow flags
    wr(7'h07);
    push("R7 cyc", SEL_CYC, 0, 0);
    push("R7 covf kept", SEL_COVF, 0, 1);
    push("R7 eovf kept", SEL_EOVF, 0, 4'b0101);
    settle();

    // R4 long overflow
    evt_in = '0;
    do_reset();
    wr(7'h41);
    idle(64);
    push("R4 long ignores short bit", SEL_COVF, 0, 0);
    settle();
    idle(4031);
    push("R4 long pre", SEL_CYC, 0, 4095);
    push("R4 long no ovf yet", SEL_COVF, 0, 0);
    settle();
    idle(1);
    push("R4 long wrap", SEL_CYC, 0, 0);
    push("R4 long ovf", SEL_COVF, 0, 1);
    settle();

    // R8: divide by 64 and prescaler clear
    do_reset();
    wr(7'h09);
    idle(63);
    push("R8 no tick yet", SEL_CYC, 0, 0);
    settle();
    idle(1);
    push("R8 first tick", SEL_CYC, 0, 1);
    settle();
    idle(64);
    push("R8 second tick", SEL_CYC, 0, 2);
    settle();
    idle(10);
    wr(7'h0D);
    idle(63);
    push("R8 prescaler cleared", SEL_CYC, 0, 0);
    settle();
    idle(1);
    push("R8 tick after clear", SEL_CYC, 0, 1);
    settle();

    // R9: prohibit-stop
    do_reset();
    evt_in = 4'b1111;
    dbg_prohibit = 1'b1;
    wr(7'h21);
    idle(10);
    push("R9 cyc stopped", SEL_CYC, 0, 0);
    push("R9 evt0 runs", SEL_EVT, 0, 10);
    settle();
    dbg_prohibit = 1'b0;
    idle(5);
    push("R9 resumes", SEL_CYC, 0, 5);
    settle();
    dbg_prohibit = 1'b1;
    wr(7'h01);
    idle(7);
    push("R9 ignored when bit clear", SEL_CYC, 0, 12);
    settle();
    dbg_prohibit = 1'b0;

    // R11: hypervisor-owned counters
    do_reset();
    hyp_split = SPLIT_W'(2);
    priv_lvl = 2'd1;
    wr(7'h01);
    idle(5);
    push("R11 evt0 low ctx", SEL_EVT, 0, 5);
    push("R11 evt1 low ctx", SEL_EVT, 1, 5);
    push("R11 evt2 reserved", SEL_EVT, 2, 0);
    push("R11 evt3 reserved", SEL_EVT, 3, 0);
    settle();
    priv_lvl = 2'd2;
    idle(3);
    push("R11 evt2 hyp", SEL_EVT, 2, 3);
    push("R11 evt0 hyp", SEL_EVT, 0, 8);
    settle();
    priv_lvl = 2'd0;
    wr(7'h03);
    push("R11 evt0 cleared", SEL_EVT, 0, 0);
    push("R11 evt2 spared", SEL_EVT, 2, 3);
    push("R11 evt3 spared", SEL_EVT, 3, 3);
    settle();
    priv_lvl = 2'd3;
    wr(7'h03);
    push("R11 evt2 cleared high", SEL_EVT, 2, 0);
    push("R11 evt3 cleared high", SEL_EVT, 3, 0);
    settle();

    // R12: export bit, counting unaffected
    wr(7'h11);
    push("R12 export", SEL_EXP, 0, 1);
    push("R12 ctrl", SEL_CTL, 0, 7'h11);
    push("R12 cyc unaffected", SEL_CYC, 0, 11);
    settle();

    // R5: full word readback
    wr(7'h7F);
    push("R5 readback", SEL_CTL, 0, 7'h79);
    push("R7 cyc cleared", SEL_CYC, 0, 0);
    settle();

    done = 1'b1;
    report();
  end
endmodule